// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. It divides the system clock down to a converter clock and steps a conversion through its phases. A conversion has a sample-and-hold strobe and then a binary search over the trial code driven to the DAC. The analog comparator reports after each trial whether the held input is at or above the trial level. At the end the block presents the finished code with a one-cycle valid pulse and raises an interrupt flag.

Software writes a one to the start input to request a single conversion. The busy output reads high until the conversion finishes. A conversion on an external channel lasts 13 converter clocks. A conversion on the internal temperature channel lasts 27 clocks, and so does the first conversion after the block is switched on. The sample point moves with the length. The block counts converter half-clocks, so the sample strobe lands exactly on a half-clock position.

Top module: `sar_sequencer`

## Requirements
- R1: Trials run from the MSB to the LSB. Each trial bit is kept when `cmpHigh` is 1, meaning the input is at or above the trial code. With an ideal comparator the result therefore equals the input level, for levels 0 to 1023.
- R2: A one on `startWr` while enabled and idle sets `startBusy` on the next clock. It stays high until the conversion completes.
- R3: The conversion starts on the first rising converter-clock edge after the request. The time from `startBusy` rising to completion is therefore longer than 2·L·h system clocks and at most 2·L·h + 2h. L is the length in converter clocks, and h is half a converter clock measured in system clocks.
- R4: A conversion on external channel 0 or 1 (`chanSel` 0, 1 or 3) lasts L = 13 converter clocks, unless it is the first one after enable.
- R5: A conversion on the temperature channel (`chanSel` = 2) lasts L = 27. So does the first conversion after `enable` rises or after reset.
- R6: Exactly one `sampleStrobe` pulse occurs per conversion. It comes 1.5 converter clocks after the start of a 13-clock conversion and 16.5 after the start of a 27-clock one. The gap from the strobe to completion is therefore 23h or 21h system clocks.
- R7: On completion, `doneValid` pulses for one cycle with `result`. In that same cycle `irqFlag` is set and `startBusy` is cleared.
- R8: While `enable` is 0, `startWr` is ignored: `startBusy` stays 0 and no conversion runs.
- R9: Clearing `enable` during a conversion aborts it. `startBusy` clears, and neither `doneValid` nor `irqFlag` is raised. The next conversion is a 27-clock one.
- R10: A one on `irqClrWr` clears `irqFlag`; if a completion happens in the same cycle, the set wins. `irqReq` is high exactly when `irqFlag` and `irqEnable` are both 1.
- R11: The converter clock period is 2^`prescSel` system clocks, so h = 2^(`prescSel`−1). A `prescSel` of 0 behaves as 1.
- R12: A `startWr` pulse during a busy conversion is ignored and yields no second conversion. A start written right after completion begins a new conversion.
- R13: After reset, `startBusy`, `irqFlag`, `irqReq`, `doneValid`, `sampleStrobe` and `trialCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter on; 0 holds idle and aborts |
| startWr | input | 1 | Write-one pulse requesting a conversion |
| chanSel | input | 2 | Channel: 0/1 external, 2 temperature, 3 treated as external |
| prescSel | input | 3 | Converter clock divide select, period 2^n system clocks |
| cmpHigh | input | 1 | Comparator: input at or above trial level |
| irqClrWr | input | 1 | Write-one pulse clearing the interrupt flag |
| irqEnable | input | 1 | Interrupt request enable |
| trialCode | output | 10 | Trial code driven to the DAC |
| sampleStrobe | output | 1 | One-cycle sample-and-hold strobe |
| startBusy | output | 1 | Read value of the start bit |
| doneValid | output | 1 | One-cycle completion pulse |
| result | output | 10 | Converted code, valid with doneValid |
| irqFlag | output | 1 | Completion interrupt flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 10-bit resolution, lengths of 13 and 27 converter clocks, and sample points at half-clock positions 3 and 33. It drives divide selections 0 through 3, so one half-clock spans 1, 2 or 4 system clocks. That range checks both the start-alignment window and the exact strobe-to-completion gap, including the case where every system clock is a half-clock tick. The levels include both rails and alternating bit patterns, so every trial bit is both kept and dropped at least once.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // strobes from control to the trial-code datapath
  typedef struct packed {
    logic clr;     // zero the trial code and bit pointer
    logic first;   // present the MSB trial
    logic decide;  // latch comparator verdict, move to next bit
    logic done;    // capture the final code
  } sarStrobes_t;

  localparam logic [1:0] CHAN_TEMP = 2'd2;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescSel,
  output logic             halfTick,
  output logic             isRise
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLimit;
  logic [SEL_W-1:0] effSel;
  logic             phase;

  always_comb begin
    effSel    = (prescSel == '0) ? SEL_W'(1) : prescSel;
    halfLimit = CNT_W'(1) << (effSel - SEL_W'(1));
    halfTick  = enable && (cnt >= halfLimit - CNT_W'(1));
    isRise    = !phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (halfTick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R11: ticks alternate rising and falling converter edges
  p_phase_toggles_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && halfTick) |=> (phase != $past(phase)));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int NORM_LEN    = 13,
  parameter int LONG_LEN    = 27,
  parameter int NORM_SAMPLE = 3,
  parameter int LONG_SAMPLE = 33
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        startWr,
  input  logic [1:0]  chanSel,
  input  logic        halfTick,
  input  logic        isRise,
  input  logic        irqClrWr,
  output sarStrobes_t stb,
  output logic        busy,
  output logic        sampleStrobe,
  output logic        irqFlag
);
  localparam int POS_W = $clog2(2 * LONG_LEN + 1);
  localparam logic [POS_W-1:0] NORM_DONE = POS_W'(2 * NORM_LEN);
  localparam logic [POS_W-1:0] LONG_DONE = POS_W'(2 * LONG_LEN);
  localparam logic [POS_W-1:0] NORM_SMP  = POS_W'(NORM_SAMPLE);
  localparam logic [POS_W-1:0] LONG_SMP  = POS_W'(LONG_SAMPLE);
  localparam logic [POS_W-1:0] TRIAL_SPAN = POS_W'(2 * RES_W);

  logic             running;
  logic             isLong;
  logic             firstPend;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] doneHalf;
  logic [POS_W-1:0] sampleHalf;
  logic [POS_W-1:0] firstHalf;
  logic             startEdge;
  logic             onTick;

  always_comb begin
    nextPos    = pos + POS_W'(1);
    doneHalf   = isLong ? LONG_DONE : NORM_DONE;
    sampleHalf = isLong ? LONG_SMP : NORM_SMP;
    firstHalf  = doneHalf - TRIAL_SPAN;
    startEdge  = enable && busy && !running && halfTick && isRise;
    onTick     = enable && running && halfTick;
    stb.clr    = startEdge || (busy && !enable);
    stb.first  = onTick && (nextPos == firstHalf);
    stb.decide = onTick && !nextPos[0] && (nextPos > firstHalf) && (nextPos <= doneHalf);
    stb.done   = onTick && (nextPos == doneHalf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      running      <= 1'b0;
      isLong       <= 1'b1;
      firstPend    <= 1'b1;
      pos          <= '0;
      sampleStrobe <= 1'b0;
    end else if (!enable) begin
      busy         <= 1'b0;
      running      <= 1'b0;
      firstPend    <= 1'b1;
      pos          <= '0;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= onTick && (nextPos == sampleHalf);
      if (startWr && !busy) begin
        busy   <= 1'b1;
        isLong <= firstPend || (chanSel == CHAN_TEMP);
      end
      if (startEdge) begin
        running <= 1'b1;
        pos     <= '0;
      end else if (onTick) begin
        pos <= nextPos;
        if (stb.done) begin
          running   <= 1'b0;
          busy      <= 1'b0;
          firstPend <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          irqFlag <= 1'b0;
    else if (stb.done)  irqFlag <= 1'b1;
    else if (irqClrWr)  irqFlag <= 1'b0;
  end

  // R8: disabling forces the busy bit low
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);
  // R6: the sample strobe only fires inside a conversion
  p_sample_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> busy);
  // R7: the flag only rises on a completion
  p_flag_from_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(stb.done));
  // R9: running never outlives busy
  p_run_within_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    running |-> busy);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobes_t      stb,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] result,
  output logic             doneValid
);
  localparam logic [RES_W-1:0] MSB_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] nextMask;

  always_comb begin
    decided  = cmpHigh ? trialCode : (trialCode & ~mask);
    nextMask = mask >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCode <= '0;
      mask      <= '0;
      result    <= '0;
      doneValid <= 1'b0;
    end else begin
      doneValid <= stb.done;
      if (stb.done) result <= decided;
      if (stb.clr) begin
        trialCode <= '0;
        mask      <= '0;
      end else if (stb.first) begin
        trialCode <= MSB_BIT;
        mask      <= MSB_BIT;
      end else if (stb.decide) begin
        trialCode <= decided | nextMask;
        mask      <= nextMask;
      end
    end
  end

  // R1: exactly one trial bit is under test at a time
  p_mask_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mask));
  // R1: bits above the pointer never change during a decision
  p_upper_bits_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decide && !stb.clr && mask != '0) |=> (trialCode & ~($past(mask) | ($past(mask) - 1'b1))) == ($past(trialCode) & ~($past(mask) | ($past(mask) - 1'b1))));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SEL_W       = 3,
  parameter int NORM_LEN    = 13,
  parameter int LONG_LEN    = 27,
  parameter int NORM_SAMPLE = 3,
  parameter int LONG_SAMPLE = 33
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             startWr,
  input  logic [1:0]       chanSel,
  input  logic [SEL_W-1:0] prescSel,
  input  logic             cmpHigh,
  input  logic             irqClrWr,
  input  logic             irqEnable,
  output logic [RES_W-1:0] trialCode,
  output logic             sampleStrobe,
  output logic             startBusy,
  output logic             doneValid,
  output logic [RES_W-1:0] result,
  output logic             irqFlag,
  output logic             irqReq
);
  logic        halfTick;
  logic        isRise;
  sarStrobes_t stb;

  sar_tick_gen #(.SEL_W(SEL_W)) uTick (
    .clk(clk), .rstN(rstN), .enable(enable), .prescSel(prescSel),
    .halfTick(halfTick), .isRise(isRise)
  );

  sar_ctrl #(
    .RES_W(RES_W), .NORM_LEN(NORM_LEN), .LONG_LEN(LONG_LEN),
    .NORM_SAMPLE(NORM_SAMPLE), .LONG_SAMPLE(LONG_SAMPLE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startWr(startWr),
    .chanSel(chanSel), .halfTick(halfTick), .isRise(isRise),
    .irqClrWr(irqClrWr), .stb(stb), .busy(startBusy),
    .sampleStrobe(sampleStrobe), .irqFlag(irqFlag)
  );

  sar_datapath #(.RES_W(RES_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .result(result), .doneValid(doneValid)
  );

  assign irqReq = irqFlag && irqEnable;

  // R7: completion coincides with busy falling and the flag set
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!startBusy && $past(startBusy) && irqFlag));
  // R2: trial code holds still while the start bit is low
  p_trial_frozen_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !startBusy |=> $stable(trialCode));
  // R6: strobe and completion never coincide
  p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleStrobe, doneValid}));
endmodule

// File: tb/sar_sequencer_test.sv
`timescale 1ns/1ps
module sar_sequencer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       startWr = 1'b0;
  logic [1:0] chanSel = 2'd0;
  logic [2:0] prescSel = 3'd1;
  logic       irqClrWr = 1'b0;
  logic       irqEnable = 1'b0;
  logic       cmpHigh;
  logic [9:0] trialCode, result;
  logic       sampleStrobe, startBusy, doneValid, irqFlag, irqReq;
  logic [9:0] stimLevel = 10'd0;

  int checks = 0;
  int errors = 0;
  bit firstPend = 1'b1;

  always #4 clk = ~clk;

  // ideal comparator model
  assign cmpHigh = (stimLevel >= trialCode);

  sar_sequencer uut (
    .clk(clk), .rstN(rstN), .enable(enable), .startWr(startWr),
    .chanSel(chanSel), .prescSel(prescSel), .cmpHigh(cmpHigh),
    .irqClrWr(irqClrWr), .irqEnable(irqEnable), .trialCode(trialCode),
    .sampleStrobe(sampleStrobe), .startBusy(startBusy), .doneValid(doneValid),
    .result(result), .irqFlag(irqFlag), .irqReq(irqReq)
  );

  // {chanSel, prescSel, level}
  localparam logic [14:0] VECS [9] = '{
    {2'd0, 3'd1, 10'd1023},
    {2'd1, 3'd1, 10'd0},
    {2'd2, 3'd2, 10'd512},
    {2'd0, 3'd3, 10'd341},
    {2'd1, 3'd1, 10'd682},
    {2'd2, 3'd1, 10'd1},
    {2'd0, 3'd2, 10'd1000},
    {2'd3, 3'd0, 10'd511},
    {2'd1, 3'd2, 10'd513}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startWr = 1'b1;
    @(negedge clk) startWr = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk) irqClrWr = 1'b1;
    @(negedge clk) irqClrWr = 1'b0;
  endtask

  task automatic runConv(input logic [1:0] ch, input logic [2:0] sel, input logic [9:0] lvl,
                         input bit midStart);
    int h, len, smp, cyc, sCyc, nS;
    bit isLong;
    h      = 1 << ((sel == 0 ? 1 : sel) - 1);
    isLong = firstPend || (ch == 2'd2);
    len    = isLong ? 27 : 13;
    smp    = isLong ? 33 : 3;
    chanSel   = ch;
    prescSel  = sel;
    stimLevel = lvl;
    pulseStart();
    check(startBusy == 1'b1, "R2 busy after start", startBusy, 1);
    cyc = 0; sCyc = 0; nS = 0;
    while (!doneValid && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (sampleStrobe) begin nS++; sCyc = cyc; end
      if (midStart && cyc == 10) startWr = 1'b1;
      else startWr = 1'b0;
      if (!doneValid && cyc > 1)
        check(startBusy == 1'b1, "R2 busy held", startBusy, 1);
    end
    check(cyc > 2*len*h && cyc <= 2*len*h + 2*h,
          isLong ? "R5 R3 R11 long length window" : "R4 R3 R11 normal length window",
          cyc, 2*len*h + 1);
    check(nS == 1, "R6 one sample strobe", nS, 1);
    check(cyc - sCyc == (2*len - smp)*h, "R6 sample to done gap", cyc - sCyc, (2*len - smp)*h);
    check(result == lvl, "R1 result equals level", result, lvl);
    check(irqFlag && !startBusy, "R7 flag set busy clear", {irqFlag, startBusy}, 2);
    firstPend = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check({startBusy, irqFlag, irqReq, doneValid, sampleStrobe} == 5'b0 && trialCode == 10'd0,
          "R13 reset state", {startBusy, irqFlag, irqReq, doneValid, sampleStrobe}, 0);
    rstN = 1'b1;

    // R8 start ignored while disabled
    pulseStart();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (startBusy || doneValid) seen = 1'b1;
      end
      check(!seen, "R8 start ignored while off", seen, 0);
    end

    @(negedge clk) enable = 1'b1;

    // table walk with back-to-back starts
    for (int i = 0; i < 9; i++)
      runConv(VECS[i][14:13], VECS[i][12:10], VECS[i][9:0], 1'b0);

    // R10 interrupt request gating and write-one clear
    @(negedge clk) irqEnable = 1'b1;
    @(negedge clk);
    check(irqReq == 1'b1, "R10 request with flag and enable", irqReq, 1);
    irqEnable = 1'b0;
    @(negedge clk);
    check(irqReq == 1'b0, "R10 request masked", irqReq, 0);
    irqEnable = 1'b1;
    clearFlag();
    check(irqFlag == 1'b0 && irqReq == 1'b0, "R10 flag cleared", irqFlag, 0);

    // R12 start while busy ignored
    runConv(2'd0, 3'd1, 10'd777, 1'b1);
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (startBusy || doneValid) extra = 1'b1;
      end
      check(!extra, "R12 no second conversion", extra, 0);
    end
    clearFlag();

    // R9 abort by clearing enable
    stimLevel = 10'd300; chanSel = 2'd0; prescSel = 3'd1;
    pulseStart();
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(startBusy == 1'b0, "R9 abort clears busy", startBusy, 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (doneValid || irqFlag) seen = 1'b1;
      end
      check(!seen, "R9 no completion after abort", seen, 0);
    end
    @(negedge clk) enable = 1'b1;
    firstPend = 1'b1;
    runConv(2'd1, 3'd1, 10'd300, 1'b0);  // R9 next is long
    @(negedge clk);
    check(doneValid == 1'b0, "R7 done is one cycle", doneValid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule